// File: doc/BRIEF.md
# QoS-Tagging Network Interface Injector

This block is the header-building stage of a network-on-chip interface. The local processor first writes configuration into a small register file. That configuration holds a priority level for each destination, a guaranteed-throughput channel flag for each destination, and a route code for each destination. The processor then issues requests. Each accepted request becomes one packet on the output: a single header flit, followed by a fixed number of payload flits.

The header carries a QoS field built from the configuration of the request's destination. Normally the field holds one of eight priority levels. While a guaranteed-throughput channel to that destination is open, the field instead holds a dedicated code, and the stored priority is ignored. The stored priority is kept, and it takes effect again once the channel is closed.

The header is built in the cycle the request is accepted. Configuration written in that same cycle therefore applies only to later requests. The output uses valid/ready flow control and holds each flit while it is stalled.

Top module: `qos_injector`

## Requirements
- R1: After reset, out_valid is 0 and req_ready is 1. Every destination is at priority 0 with no open channel and route 0, so the first header to any destination has QoS field 4'b0000 and route field 0.
- R2: A write with cfg_op=0 stores cfg_data[2:0] as the priority of destination cfg_dst. Later headers to that destination, with no channel open, carry QoS field {1'b0, priority}.
- R3: A write with cfg_op=1 returns the priority of destination cfg_dst to 0 and leaves every other destination unchanged.
- R4: A write with cfg_op=2 returns the priority of every destination to 0. Open channels and routes are not affected.
- R5: A write with cfg_op=3 opens a guaranteed channel to cfg_dst, and cfg_op=4 closes it. While the channel is open, the header QoS field is 4'b1000 whatever the stored priority. After the close, the stored priority shows again. A header never carries QoS bit 3 set together with a nonzero priority.
- R6: A write with cfg_op=5 stores cfg_data as the route of destination cfg_dst. That route appears in bits [7:0] of later headers to that destination.
- R7: The header flit layout is: bits [15:14] = number of payload flits (NPAY), bits [13:12] = SRC_ID, bits [11:8] = QoS field, bits [7:0] = route.
- R8: The header appears on out_flit, with out_valid high, in the cycle after the request is accepted. After it come NPAY payload flits, taken from req_payload lowest slice first; out_last marks the final flit. req_ready is low while a packet is in flight. req_ready returns to 1, with out_valid 0, in the cycle after the last flit is taken.
- R9: While out_valid is 1 and out_ready is 0, out_flit and out_last hold their values into the next cycle.
- R10: A configuration write in the same cycle as an accepted request does not change that request's header. Writes with cfg_op 6 or 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Operation: 0 set priority, 1 clear priority, 2 clear all priorities, 3 open channel, 4 close channel, 5 load route |
| cfg_dst | input | 2 | Destination addressed by the write |
| cfg_data | input | 8 | Priority (bits 2:0) or route value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_dst | input | 2 | Destination of the request |
| req_payload | input | 32 | Payload, sent as NPAY flits, low slice first |
| out_valid | output | 1 | Output flit present |
| out_ready | input | 1 | Downstream takes the flit |
| out_flit | output | 16 | Header or payload flit |
| out_last | output | 1 | Final flit of the packet |

## Verification
On every cycle, the assertions check the shape of each packet: the header follows an accepted request in the next cycle, exactly NPAY payload flits precede out_last, and the block goes idle after the last flit. They also check that stalled flits hold, that the sender and length fields are correct, and that the guaranteed-throughput code never mixes with a priority. The values that configuration puts into a header can only be shown by the bench's scenarios. These cover the priority each destination receives, selective and global clearing, the route lookup, restoring the priority after a channel closes, and the snapshot taken when a write and a request share a cycle. The bench sweeps every priority level on every destination and compares each header with one it assembles from its own model.

// File: rtl/qos_injector.sv
module qos_injector #(
  parameter int NDST    = 4,
  parameter int SRC_ID  = 1,
  parameter int SRC_W   = 2,
  parameter int FLIT_W  = 16,
  parameter int ROUTE_W = 8,
  parameter int NPAY    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_op,
  input  logic [$clog2(NDST)-1:0]  cfg_dst,
  input  logic [ROUTE_W-1:0]       cfg_data,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [$clog2(NDST)-1:0]  req_dst,
  input  logic [NPAY*FLIT_W-1:0]   req_payload,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [FLIT_W-1:0]        out_flit,
  output logic                     out_last
);
  localparam int PRIO_W = 3;
  localparam int QOS_W  = PRIO_W + 1;
  localparam int OTH_W  = FLIT_W - SRC_W - QOS_W - ROUTE_W;
  localparam int CNT_W  = $clog2(NPAY + 1);
  localparam int PKT_W  = (NPAY + 1) * FLIT_W;

  localparam logic [2:0] OP_SETP  = 3'd0;
  localparam logic [2:0] OP_CLRP  = 3'd1;
  localparam logic [2:0] OP_CLRA  = 3'd2;
  localparam logic [2:0] OP_OPEN  = 3'd3;
  localparam logic [2:0] OP_CLOSE = 3'd4;
  localparam logic [2:0] OP_ROUTE = 3'd5;

  logic [PRIO_W-1:0]  prio_q  [NDST];
  logic [ROUTE_W-1:0] route_q [NDST];
  logic [NDST-1:0]    gt_q;

  logic               busy_q;
  logic [CNT_W-1:0]   idx_q;
  logic [PKT_W-1:0]   pkt_q;

  logic               accept, take;
  logic [QOS_W-1:0]   qos;
  logic [FLIT_W-1:0]  hdr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gt_q <= '0;
      for (int i = 0; i < NDST; i++) begin
        prio_q[i]  <= '0;
        route_q[i] <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_op)
        OP_SETP:  prio_q[cfg_dst]  <= cfg_data[PRIO_W-1:0];
        OP_CLRP:  prio_q[cfg_dst]  <= '0;
        OP_CLRA:  for (int i = 0; i < NDST; i++) prio_q[i] <= '0;
        OP_OPEN:  gt_q[cfg_dst]    <= 1'b1;
        OP_CLOSE: gt_q[cfg_dst]    <= 1'b0;
        OP_ROUTE: route_q[cfg_dst] <= cfg_data;
        default:  ;
      endcase
    end
  end

  assign accept = req_valid && req_ready;
  assign take   = out_valid && out_ready;
  assign qos    = gt_q[req_dst] ? {1'b1, {PRIO_W{1'b0}}} : {1'b0, prio_q[req_dst]};
  assign hdr    = {OTH_W'(NPAY), SRC_W'(SRC_ID), qos, route_q[req_dst]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      pkt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      pkt_q  <= {req_payload, hdr};
    end else if (take) begin
      pkt_q <= pkt_q >> FLIT_W;
      if (idx_q == CNT_W'(NPAY)) busy_q <= 1'b0;
      else                       idx_q  <= idx_q + 1'b1;
    end
  end

  assign req_ready = !busy_q;
  assign out_valid = busy_q;
  assign out_flit  = pkt_q[FLIT_W-1:0];
  assign out_last  = busy_q && (idx_q == CNT_W'(NPAY));
endmodule

module qos_injector_chk #(
  parameter int SRC_ID  = 1,
  parameter int SRC_W   = 2,
  parameter int FLIT_W  = 16,
  parameter int ROUTE_W = 8,
  parameter int NPAY    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FLIT_W-1:0] out_flit,
  input logic              out_last
);
  localparam int QOS_W = 4;
  localparam int OTH_W = FLIT_W - SRC_W - QOS_W - ROUTE_W;
  localparam int CNT_W = $clog2(NPAY + 1);

  logic             at_hdr;
  logic [CNT_W-1:0] seen;
  logic [QOS_W-1:0] qf;

  assign qf = out_flit[ROUTE_W +: QOS_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      at_hdr <= 1'b1;
      seen   <= '0;
    end else if (out_valid && out_ready) begin
      if (out_last) begin
        at_hdr <= 1'b1;
        seen   <= '0;
      end else begin
        at_hdr <= 1'b0;
        seen   <= seen + 1'b1;
      end
    end
  end

  // R8
  accept_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> out_valid && at_hdr && !out_last);

  // R8
  flit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> seen == CNT_W'(NPAY));

  // R8
  back_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && req_ready);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_flit) && $stable(out_last));

  // R5
  gt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && at_hdr |-> !qf[QOS_W-1] || qf[QOS_W-2:0] == '0);

  // R7
  hdr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && at_hdr |-> out_flit[ROUTE_W+QOS_W +: SRC_W] == SRC_W'(SRC_ID)
                            && out_flit[FLIT_W-1 -: OTH_W] == OTH_W'(NPAY));
endmodule

bind qos_injector qos_injector_chk #(
  .SRC_ID(SRC_ID), .SRC_W(SRC_W), .FLIT_W(FLIT_W), .ROUTE_W(ROUTE_W), .NPAY(NPAY)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit), .out_last(out_last)
);

// File: tb/test_qos_injector.sv
`timescale 1ns/1ps
module test_qos_injector;
  localparam int NDST = 4;
  localparam int NPAY = 2;
  localparam int SRC  = 1;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_op = 0;
  logic [1:0]  cfg_dst = 0;
  logic [7:0]  cfg_data = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [1:0]  req_dst = 0;
  logic [31:0] req_payload = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [15:0] out_flit;
  logic        out_last;

  int vecs = 0;
  int errs = 0;

  logic [2:0] m_prio  [NDST];
  logic [7:0] m_route [NDST];
  logic       m_gt    [NDST];

  always #2 clk = ~clk;

  qos_injector i_qos_injector (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_dst(cfg_dst),
    .cfg_data(cfg_data), .req_valid(req_valid), .req_ready(req_ready), .req_dst(req_dst),
    .req_payload(req_payload), .out_valid(out_valid), .out_ready(out_ready),
    .out_flit(out_flit), .out_last(out_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_hdr(input int d);
    logic [3:0] q;
    q = m_gt[d] ? 4'b1000 : {1'b0, m_prio[d]};
    return {2'(NPAY), 2'(SRC), q, m_route[d]};
  endfunction

  task automatic cfg(input logic [2:0] op, input int d, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_op = op; cfg_dst = 2'(d); cfg_data = v;
    @(negedge clk);
    cfg_we = 0;
    case (op)
      3'd0: m_prio[d] = v[2:0];
      3'd1: m_prio[d] = 0;
      3'd2: for (int i = 0; i < NDST; i++) m_prio[i] = 0;
      3'd3: m_gt[d] = 1;
      3'd4: m_gt[d] = 0;
      3'd5: m_route[d] = v;
      default: ;
    endcase
  endtask

  // Drives one request; expected header given by caller. Optional write in the accept cycle.
  task automatic send(input string req, input int d, input logic [31:0] pay,
                      input logic [15:0] exp_hdr, input bit stall,
                      input bit same_wr, input logic [2:0] wop, input logic [7:0] wv);
    @(negedge clk);
    check("R8 ready before request", {31'b0, req_ready}, 1);
    req_valid = 1; req_dst = 2'(d); req_payload = pay;
    if (same_wr) begin cfg_we = 1; cfg_op = wop; cfg_dst = 2'(d); cfg_data = wv; end
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    check("R8 header valid", {30'b0, out_valid, req_ready}, 2);
    check(req, {16'b0, out_flit}, {16'b0, exp_hdr});
    check("R8 header not last", {31'b0, out_last}, 0);
    if (stall) begin
      out_ready = 0;
      @(negedge clk);
      check("R9 stalled header held", {15'b0, out_valid, out_flit}, {15'b0, 1'b1, exp_hdr});
      out_ready = 1;
    end
    for (int k = 0; k < NPAY; k++) begin
      @(negedge clk);
      check("R8 payload flit", {14'b0, out_valid, out_last, out_flit},
            {14'b0, 1'b1, 1'(k == NPAY - 1), pay[k*16 +: 16]});
      if (stall && k == NPAY - 1) begin
        out_ready = 0;
        @(negedge clk);
        check("R9 stalled last held", {15'b0, out_last, out_flit}, {15'b0, 1'b1, pay[k*16 +: 16]});
        out_ready = 1;
      end
    end
    @(negedge clk);
    check("R8 idle after packet", {30'b0, out_valid, req_ready}, 1);
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < NDST; i++) begin m_prio[i] = 0; m_route[i] = 0; m_gt[i] = 0; end
    #1;
    check("R1 reset outputs", {30'b0, out_valid, req_ready}, 1);
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int d = 0; d < NDST; d++)
      send("R1 reset header", d, 32'h1000_0000 + d, model_hdr(d), 0, 0, 0, 0);

    // R6 routes
    for (int d = 0; d < NDST; d++) cfg(3'd5, d, 8'(8'h3C + 17 * d));
    for (int d = 0; d < NDST; d++)
      send("R6 route field", d, 32'hA5A5_0000 + d, model_hdr(d), 0, 0, 0, 0);

    // R2 and R7: sweep every priority on every destination
    for (int d = 0; d < NDST; d++)
      for (int p = 0; p < 8; p++) begin
        cfg(3'd0, d, 8'(p));
        send("R2 R7 priority header", d, {8'(p), 8'(d), 16'hBEEF}, model_hdr(d), p == 5, 0, 0, 0);
      end

    for (int d = 0; d < NDST; d++) cfg(3'd0, d, 8'(d + 3));
    // R3 clear one
    cfg(3'd1, 2, 0);
    for (int d = 0; d < NDST; d++)
      send("R3 clear one destination", d, 32'h3333_0000 + d, model_hdr(d), 0, 0, 0, 0);

    // R5 channels
    cfg(3'd3, 1, 0);
    cfg(3'd3, 3, 0);
    for (int d = 0; d < NDST; d++)
      send("R5 channel open", d, 32'h5555_0000 + d, model_hdr(d), d == 3, 0, 0, 0);
    cfg(3'd0, 1, 8'd7);
    send("R5 priority ignored while open", 1, 32'h5A5A_5A5A, {2'(NPAY), 2'(SRC), 4'b1000, m_route[1]}, 0, 0, 0, 0);
    cfg(3'd4, 1, 0);
    send("R5 priority back after close", 1, 32'h5B5B_5B5B, {2'(NPAY), 2'(SRC), 4'b0111, m_route[1]}, 0, 0, 0, 0);

    // R4 clear all, channel on 3 kept
    cfg(3'd2, 0, 0);
    for (int d = 0; d < NDST; d++)
      send("R4 clear all", d, 32'h4444_0000 + d, model_hdr(d), 0, 0, 0, 0);
    cfg(3'd4, 3, 0);

    // R10 same-cycle write uses old value, then new value
    send("R10 snapshot at accept", 0, 32'hCAFE_0001, model_hdr(0), 0, 1, 3'd0, 8'd6);
    m_prio[0] = 6;
    send("R10 write visible next", 0, 32'hCAFE_0002, model_hdr(0), 0, 0, 0, 0);
    send("R10 open in accept cycle", 2, 32'hCAFE_0003, model_hdr(2), 0, 1, 3'd3, 0);
    m_gt[2] = 1;
    send("R10 channel visible next", 2, 32'hCAFE_0004, model_hdr(2), 0, 0, 0, 0);
    // R10 ignored opcodes
    cfg(3'd6, 0, 8'hFF);
    cfg(3'd7, 2, 8'hFF);
    send("R10 op6 ignored", 0, 32'hD00D_0000, model_hdr(0), 0, 0, 0, 0);
    send("R10 op7 ignored", 2, 32'hD00D_0002, model_hdr(2), 0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule